// File: doc/BRIEF.md
# Audio Serial Port Clock Generator

This block makes the bit clocks and frame syncs for the transmit and receive halves of an I2S-style audio serial port. It also makes the pin output enables for them. Each half picks one of three clock sources:

- **Internal:** an auxiliary clock runs through a master-clock divider and then a bit-clock divider.
- **Mixed:** an external master clock on the high-frequency pin feeds the bit-clock divider alone.
- **External:** the bit clock and frame sync come straight from their pins, and the master-clock path is bypassed.

A sync switch makes the receive half run on the transmit bit clock and frame sync, so the receive pins play no part. For a receive-only link clocked from outside, the switch must be clear.

The whole block runs on one fast clock, `clk_i`. The auxiliary clock is modelled as a virtual clock that changes level on every `clk_i` cycle. External pins pass through two-flop synchronizers, and their edges are counted as clock edges. Dividers count both edges of their source clock, so every ratio from 1 to 32 gives equal high and low times. A ratio of 1 passes the source through. In internal and mixed modes, the frame sync changes state after a programmable number N of falling bit-clock edges, so a frame lasts 2N bit clocks. Mode pins are static configuration: a change of mode clears the dividers and is not glitch-free. No data path crosses this block, so no port uses a valid/ready handshake and nothing at its edge applies back-pressure.

Top module: `audio_clkgen`

## Requirements
- R1: While reset is asserted, every clock output (`*_hf_o`, `*_bclk_o`, `*_fs_o`) is low.
- R2: Mode encoding is 2'b00 internal, 2'b01 mixed, 2'b10 external (2'b11 acts as external). Divider fields hold ratio-1. In internal mode the master clock has a period of 2*HFR `clk_i` cycles and the bit clock a period of 2*HFR*BR, each with equal high and low time (HFR = `hf_div`+1, BR = `bit_div`+1).
- R3: A master-clock ratio of 1 (`hf_div` = 0) passes the auxiliary clock through, giving a 2-cycle master period.
- R4: `fs_len` holds N-1. In internal and mixed modes the frame sync has a period of 2N bit clocks and changes only while the bit clock is low. With N = 32, bit-clock ratios of 4 and 6 give frames of 256 and 384 master clocks when HFR = 1.
- R5: In mixed mode the bit clock period is BR times the period of the `hf_pin` input, and the `hf_div` setting has no effect.
- R6: In external mode, `bclk_o` and `fs_o` follow the bit-clock and frame pins at the pin rate, and `hf_o` stays low.
- R7: `bclk_oe_o` and `fs_oe_o` are high in internal and mixed mode and low in external mode.
- R8: `hf_oe_o` is high only in internal mode with `hf_drive_i` set.
- R9: With `sync_i` set, the receive bit clock and frame sync copy the transmit ones, the receive pin inputs have no effect, and every receive output enable is low.
- R10: With `sync_i` clear, the receive half runs from its own configuration and pins, independent of transmit.
- R11: A mode change clears the dividers: after a switch into internal mode, `bclk_o` is low for HFR*BR+1 samples and then rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock; also paces the auxiliary clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Receive half uses transmit bit clock and frame sync |
| tx_mode_i | input | 2 | Transmit clock source |
| tx_hf_div_i | input | DIV_W | Transmit master divider, ratio-1 |
| tx_bit_div_i | input | DIV_W | Transmit bit divider, ratio-1 |
| tx_fs_len_i | input | FS_W | Transmit falling bit edges per frame half, minus 1 |
| tx_hf_drive_i | input | 1 | Drive transmit master clock out in internal mode |
| tx_hf_pin_i | input | 1 | Transmit high-frequency clock pin in |
| tx_bclk_pin_i | input | 1 | Transmit bit-clock pin in |
| tx_fs_pin_i | input | 1 | Transmit frame-sync pin in |
| rx_mode_i | input | 2 | Receive clock source |
| rx_hf_div_i | input | DIV_W | Receive master divider, ratio-1 |
| rx_bit_div_i | input | DIV_W | Receive bit divider, ratio-1 |
| rx_fs_len_i | input | FS_W | Receive falling bit edges per frame half, minus 1 |
| rx_hf_drive_i | input | 1 | Drive receive master clock out in internal mode |
| rx_hf_pin_i | input | 1 | Receive high-frequency clock pin in |
| rx_bclk_pin_i | input | 1 | Receive bit-clock pin in |
| rx_fs_pin_i | input | 1 | Receive frame-sync pin in |
| tx_hf_o | output | 1 | Transmit master clock |
| tx_hf_oe_o | output | 1 | Transmit master pin output enable |
| tx_bclk_o | output | 1 | Transmit bit clock |
| tx_bclk_oe_o | output | 1 | Transmit bit-clock pin output enable |
| tx_fs_o | output | 1 | Transmit frame sync |
| tx_fs_oe_o | output | 1 | Transmit frame-sync pin output enable |
| rx_hf_o | output | 1 | Receive master clock |
| rx_hf_oe_o | output | 1 | Receive master pin output enable |
| rx_bclk_o | output | 1 | Receive bit clock |
| rx_bclk_oe_o | output | 1 | Receive bit-clock pin output enable |
| rx_fs_o | output | 1 | Receive frame sync |
| rx_fs_oe_o | output | 1 | Receive frame-sync pin output enable |

## Verification
The bench builds the block with its defaults: DIV_W = 5, which gives ratios 1 to 32, and FS_W = 6, which gives frames of up to 64 bit clocks per half. At run time it programs small divider ratios, so whole master, bit and frame periods fit in a few hundred cycles. It also programs the N = 32 settings that show the 256x and 384x master-to-frame ratios. The ratio of 1 is within reach, which exposes the pass-through corner. Pin stimulus at rates unrelated to the divided clocks shows that the ignored inputs really are ignored.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;
  typedef enum logic [1:0] {
    SRC_INT = 2'b00,
    SRC_MIX = 2'b01,
    SRC_EXT = 2'b10,
    SRC_RSV = 2'b11
  } clk_src_e;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned NUM_DIR = 2;
endpackage

// File: rtl/acg_pin_sync.sv
module acg_pin_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = audio_clkgen_pkg::SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign lvl_o = stage_q[STAGES-1];
endmodule

// File: rtl/acg_edge_div.sv
module acg_edge_div #(
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             clr_i,
  input  logic             src_edge_i,
  input  logic [DIV_W-1:0] div_m1_i,
  output logic             lvl_o,
  output logic             edge_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             lvl_q;
  logic             edge_q;

  // Counts both source edges, so high and low phases match for any ratio.
  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      edge_q <= 1'b0;
      if (src_edge_i) begin
        if (cnt_q >= div_m1_i) begin
          cnt_q  <= '0;
          lvl_q  <= ~lvl_q;
          edge_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign lvl_o  = lvl_q;
  assign edge_o = edge_q;

  // R2: output level moves only in answer to a source edge
  a_r2_toggle_on_src_edge: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$stable(lvl_q) && !$past(clr_i)) |-> $past(src_edge_i));
endmodule

// File: rtl/acg_dir.sv
module acg_dir
  import audio_clkgen_pkg::*;
#(
  parameter int unsigned DIV_W = 5,
  parameter int unsigned FS_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  clk_src_e         mode_i,
  input  logic [DIV_W-1:0] hf_div_i,
  input  logic [DIV_W-1:0] bit_div_i,
  input  logic [FS_W-1:0]  fs_len_i,
  input  logic             hf_drive_i,
  input  logic             hf_pin_i,
  input  logic             bclk_pin_i,
  input  logic             fs_pin_i,
  output logic             hf_o,
  output logic             hf_oe_o,
  output logic             bclk_o,
  output logic             bclk_oe_o,
  output logic             fs_o,
  output logic             fs_oe_o
);
  localparam int unsigned NPIN = 3;

  logic [NPIN-1:0] pin_lvl;
  logic            hfp_prev_q, bcp_prev_q;
  logic            hfp_edge, bcp_edge;
  clk_src_e        mode_q;
  logic            clr;
  logic            is_int, is_mix, is_ext;
  logic            hf_lvl, hf_edge, bit_lvl, bit_edge, bit_fall;
  logic            bit_src_edge;
  logic [FS_W-1:0] fs_cnt_q;
  logic            fs_q;

  acg_pin_sync #(.W(NPIN)) u_pins (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .pin_i ({fs_pin_i, bclk_pin_i, hf_pin_i}),
    .lvl_o (pin_lvl)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hfp_prev_q <= 1'b0;
      bcp_prev_q <= 1'b0;
      mode_q     <= SRC_INT;
    end else begin
      hfp_prev_q <= pin_lvl[0];
      bcp_prev_q <= pin_lvl[1];
      mode_q     <= mode_i;
    end
  end

  assign hfp_edge = pin_lvl[0] ^ hfp_prev_q;
  assign bcp_edge = pin_lvl[1] ^ bcp_prev_q;
  assign clr      = (mode_i != mode_q);
  assign is_int   = (mode_i == SRC_INT);
  assign is_mix   = (mode_i == SRC_MIX);
  assign is_ext   = !(is_int || is_mix);

  // Master divider: the auxiliary clock changes level every cycle.
  acg_edge_div #(.DIV_W(DIV_W)) u_hf_div (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .clr_i      (clr),
    .src_edge_i (is_int),
    .div_m1_i   (hf_div_i),
    .lvl_o      (hf_lvl),
    .edge_o     (hf_edge)
  );

  assign bit_src_edge = is_int ? hf_edge : (is_mix ? hfp_edge : 1'b0);

  acg_edge_div #(.DIV_W(DIV_W)) u_bit_div (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .clr_i      (clr),
    .src_edge_i (bit_src_edge),
    .div_m1_i   (bit_div_i),
    .lvl_o      (bit_lvl),
    .edge_o     (bit_edge)
  );

  assign bit_fall = bit_edge && !bit_lvl;

  // Frame sync: changes state after N falling bit-clock edges.
  always_ff @(posedge clk_i) begin
    if (rst_i || clr) begin
      fs_cnt_q <= '0;
      fs_q     <= 1'b0;
    end else if (!is_ext && bit_fall) begin
      if (fs_cnt_q >= fs_len_i) begin
        fs_cnt_q <= '0;
        fs_q     <= ~fs_q;
      end else begin
        fs_cnt_q <= fs_cnt_q + 1'b1;
      end
    end
  end

  assign hf_o      = is_int ? hf_lvl : 1'b0;
  assign hf_oe_o   = is_int && hf_drive_i;
  assign bclk_o    = is_ext ? pin_lvl[1] : bit_lvl;
  assign bclk_oe_o = !is_ext;
  assign fs_o      = is_ext ? pin_lvl[2] : fs_q;
  assign fs_oe_o   = !is_ext;

  // R4: generated frame sync moves only after a falling bit-clock edge
  a_r4_fs_on_bit_fall: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$stable(fs_q) && !$past(clr)) |-> $past(bit_fall));

  // R8: master clock is driven out only when the bit clock is also driven
  a_r8_hf_oe_needs_bclk_oe: assert property (@(posedge clk_i) disable iff (rst_i)
    hf_oe_o |-> bclk_oe_o);
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clkgen_pkg::*;
#(
  parameter int unsigned DIV_W = 5,
  parameter int unsigned FS_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             sync_i,
  input  logic [1:0]       tx_mode_i,
  input  logic [DIV_W-1:0] tx_hf_div_i,
  input  logic [DIV_W-1:0] tx_bit_div_i,
  input  logic [FS_W-1:0]  tx_fs_len_i,
  input  logic             tx_hf_drive_i,
  input  logic             tx_hf_pin_i,
  input  logic             tx_bclk_pin_i,
  input  logic             tx_fs_pin_i,
  input  logic [1:0]       rx_mode_i,
  input  logic [DIV_W-1:0] rx_hf_div_i,
  input  logic [DIV_W-1:0] rx_bit_div_i,
  input  logic [FS_W-1:0]  rx_fs_len_i,
  input  logic             rx_hf_drive_i,
  input  logic             rx_hf_pin_i,
  input  logic             rx_bclk_pin_i,
  input  logic             rx_fs_pin_i,
  output logic             tx_hf_o,
  output logic             tx_hf_oe_o,
  output logic             tx_bclk_o,
  output logic             tx_bclk_oe_o,
  output logic             tx_fs_o,
  output logic             tx_fs_oe_o,
  output logic             rx_hf_o,
  output logic             rx_hf_oe_o,
  output logic             rx_bclk_o,
  output logic             rx_bclk_oe_o,
  output logic             rx_fs_o,
  output logic             rx_fs_oe_o
);
  localparam int unsigned TXI = 0;
  localparam int unsigned RXI = 1;

  logic [NUM_DIR-1:0][1:0]       mode_a;
  logic [NUM_DIR-1:0][DIV_W-1:0] hfd_a, bd_a;
  logic [NUM_DIR-1:0][FS_W-1:0]  fl_a;
  logic [NUM_DIR-1:0]            drv_a, hfp_a, bcp_a, fsp_a;
  logic [NUM_DIR-1:0]            hf_a, hfoe_a, bc_a, bcoe_a, fs_a, fsoe_a;

  assign mode_a = {rx_mode_i, tx_mode_i};
  assign hfd_a  = {rx_hf_div_i, tx_hf_div_i};
  assign bd_a   = {rx_bit_div_i, tx_bit_div_i};
  assign fl_a   = {rx_fs_len_i, tx_fs_len_i};
  assign drv_a  = {rx_hf_drive_i, tx_hf_drive_i};
  assign hfp_a  = {rx_hf_pin_i, tx_hf_pin_i};
  assign bcp_a  = {rx_bclk_pin_i, tx_bclk_pin_i};
  assign fsp_a  = {rx_fs_pin_i, tx_fs_pin_i};

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    acg_dir #(.DIV_W(DIV_W), .FS_W(FS_W)) u_dir (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .mode_i     (clk_src_e'(mode_a[d])),
      .hf_div_i   (hfd_a[d]),
      .bit_div_i  (bd_a[d]),
      .fs_len_i   (fl_a[d]),
      .hf_drive_i (drv_a[d]),
      .hf_pin_i   (hfp_a[d]),
      .bclk_pin_i (bcp_a[d]),
      .fs_pin_i   (fsp_a[d]),
      .hf_o       (hf_a[d]),
      .hf_oe_o    (hfoe_a[d]),
      .bclk_o     (bc_a[d]),
      .bclk_oe_o  (bcoe_a[d]),
      .fs_o       (fs_a[d]),
      .fs_oe_o    (fsoe_a[d])
    );
  end

  assign tx_hf_o      = hf_a[TXI];
  assign tx_hf_oe_o   = hfoe_a[TXI];
  assign tx_bclk_o    = bc_a[TXI];
  assign tx_bclk_oe_o = bcoe_a[TXI];
  assign tx_fs_o      = fs_a[TXI];
  assign tx_fs_oe_o   = fsoe_a[TXI];

  // Sync: receive borrows transmit timing and releases its pins.
  assign rx_hf_o      = sync_i ? 1'b0 : hf_a[RXI];
  assign rx_hf_oe_o   = sync_i ? 1'b0 : hfoe_a[RXI];
  assign rx_bclk_o    = sync_i ? bc_a[TXI] : bc_a[RXI];
  assign rx_bclk_oe_o = sync_i ? 1'b0 : bcoe_a[RXI];
  assign rx_fs_o      = sync_i ? fs_a[TXI] : fs_a[RXI];
  assign rx_fs_oe_o   = sync_i ? 1'b0 : fsoe_a[RXI];

  // R9: under sync, receive bit clock moves only together with transmit
  a_r9_rx_tracks_tx: assert property (@(posedge clk_i) disable iff (rst_i)
    (sync_i && $past(sync_i) && !$stable(rx_bclk_o)) |-> !$stable(tx_bclk_o));

  // R9: under sync no receive pin is driven
  a_r9_rx_pins_released: assert property (@(posedge clk_i) disable iff (rst_i)
    sync_i |-> !(rx_hf_oe_o || rx_bclk_oe_o || rx_fs_oe_o));
endmodule

// File: tb/audio_clkgen_tb.sv
module audio_clkgen_tb;
  localparam int DIV_W = 5;
  localparam int FS_W  = 6;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_i = 1'b0;
  logic [1:0] tx_mode = 2'b00, rx_mode = 2'b00;
  logic [DIV_W-1:0] tx_hfd = '0, tx_bd = '0, rx_hfd = '0, rx_bd = '0;
  logic [FS_W-1:0] tx_fl = '0, rx_fl = '0;
  logic tx_drv = 1'b0, rx_drv = 1'b0;
  logic tx_hfp = 1'b0, tx_bcp = 1'b0, tx_fsp = 1'b0;
  logic rx_hfp = 1'b0, rx_bcp = 1'b0, rx_fsp = 1'b0;
  logic tx_hf, tx_hfoe, tx_bc, tx_bcoe, tx_fs, tx_fsoe;
  logic rx_hf, rx_hfoe, rx_bc, rx_bcoe, rx_fs, rx_fsoe;

  // pin stimulus half periods in cycles, 0 = hold
  int h_txhf = 0, h_rxbc = 0, h_rxfs = 0;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  audio_clkgen #(.DIV_W(DIV_W), .FS_W(FS_W)) u_dut (
    .clk_i(clk), .rst_i(rst), .sync_i(sync_i),
    .tx_mode_i(tx_mode), .tx_hf_div_i(tx_hfd), .tx_bit_div_i(tx_bd),
    .tx_fs_len_i(tx_fl), .tx_hf_drive_i(tx_drv),
    .tx_hf_pin_i(tx_hfp), .tx_bclk_pin_i(tx_bcp), .tx_fs_pin_i(tx_fsp),
    .rx_mode_i(rx_mode), .rx_hf_div_i(rx_hfd), .rx_bit_div_i(rx_bd),
    .rx_fs_len_i(rx_fl), .rx_hf_drive_i(rx_drv),
    .rx_hf_pin_i(rx_hfp), .rx_bclk_pin_i(rx_bcp), .rx_fs_pin_i(rx_fsp),
    .tx_hf_o(tx_hf), .tx_hf_oe_o(tx_hfoe), .tx_bclk_o(tx_bc),
    .tx_bclk_oe_o(tx_bcoe), .tx_fs_o(tx_fs), .tx_fs_oe_o(tx_fsoe),
    .rx_hf_o(rx_hf), .rx_hf_oe_o(rx_hfoe), .rx_bclk_o(rx_bc),
    .rx_bclk_oe_o(rx_bcoe), .rx_fs_o(rx_fs), .rx_fs_oe_o(rx_fsoe)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", WATCHDOG);
    finish_run();
  end

  initial begin : pin_gen
    int c_a, c_b, c_c;
    c_a = 0; c_b = 0; c_c = 0;
    forever begin
      @(negedge clk);
      if (h_txhf > 0) begin c_a++; if (c_a >= h_txhf) begin c_a = 0; tx_hfp = ~tx_hfp; end end
      if (h_rxbc > 0) begin c_b++; if (c_b >= h_rxbc) begin c_b = 0; rx_bcp = ~rx_bcp; end end
      if (h_rxfs > 0) begin c_c++; if (c_c >= h_rxfs) begin c_c = 0; rx_fsp = ~rx_fsp; end end
    end
  end

  function automatic logic sig(input int sel);
    case (sel)
      0: return tx_hf;
      1: return tx_bc;
      2: return tx_fs;
      3: return rx_hf;
      4: return rx_bc;
      default: return rx_fs;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(input int sel, output int per, output int hi);
    logic prev, cur;
    per = 0; hi = 0;
    prev = sig(sel);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      cur = sig(sel);
      if (!prev && cur) break;
      prev = cur;
    end
    prev = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      cur = sig(sel);
      per++;
      if (cur) hi++;
      if (!prev && cur) break;
      prev = cur;
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    settle(3);
    chk("R1 tx_hf", int'(tx_hf), 0);
    chk("R1 tx_bclk", int'(tx_bc), 0);
    chk("R1 tx_fs", int'(tx_fs), 0);
    chk("R1 rx_bclk", int'(rx_bc), 0);
    chk("R1 rx_fs", int'(rx_fs), 0);
    rst = 1'b0;
  endtask

  task automatic t_internal();
    int p, h;
    tx_mode = 2'b00; tx_hfd = 5'd2; tx_bd = 5'd1; tx_fl = 6'd3; tx_drv = 1'b1;
    settle(4);
    measure(0, p, h);
    chk("R2 hf period", p, 6);
    chk("R2 hf high", h, 3);
    measure(1, p, h);
    chk("R2 bclk period", p, 12);
    chk("R2 bclk high", h, 6);
    chk("R7 bclk_oe internal", int'(tx_bcoe), 1);
    chk("R7 fs_oe internal", int'(tx_fsoe), 1);
    chk("R8 hf_oe internal drive", int'(tx_hfoe), 1);
    tx_drv = 1'b0;
    settle(1);
    chk("R8 hf_oe drive clear", int'(tx_hfoe), 0);
    tx_hfd = 5'd0;
    settle(4);
    measure(0, p, h);
    chk("R3 pass-through period", p, 2);
    chk("R3 pass-through high", h, 1);
  endtask

  task automatic t_frame(input int bd_m1, input int exp_hf_per_frame);
    int p, h, pb, hb;
    tx_mode = 2'b00; tx_hfd = 5'd0; tx_bd = bd_m1[DIV_W-1:0]; tx_fl = 6'd31;
    settle(4);
    measure(1, pb, hb);
    chk("R4 bclk period", pb, 2 * (bd_m1 + 1));
    measure(2, p, h);
    chk("R4 fs period in bclks", p / pb, 64);
    chk("R4 hf per frame", p / 2, exp_hf_per_frame);
    chk("R4 fs high half", h, p / 2);
    // at the sample where fs rose, bclk must be low
    measure(2, p, h);
    chk("R4 bclk low at fs change", int'(tx_bc), 0);
  endtask

  task automatic t_mixed();
    int p, h;
    tx_mode = 2'b01; tx_hfd = 5'd7; tx_bd = 5'd2; tx_fl = 6'd1; tx_drv = 1'b1;
    h_txhf = 3;
    settle(20);
    measure(1, p, h);
    chk("R5 bclk from hf pin", p, 18);
    tx_hfd = 5'd0;
    settle(2);
    measure(1, p, h);
    chk("R5 hf_div ignored", p, 18);
    measure(2, p, h);
    chk("R4 fs period mixed", p, 4 * 18);
    chk("R7 bclk_oe mixed", int'(tx_bcoe), 1);
    chk("R8 hf_oe mixed", int'(tx_hfoe), 0);
    h_txhf = 0;
  endtask

  task automatic t_external();
    int p, h, hfseen;
    sync_i = 1'b0;
    rx_mode = 2'b10; rx_hfd = 5'd0; rx_bd = 5'd0; rx_drv = 1'b1;
    h_rxbc = 5; h_rxfs = 40;
    rx_hfp = 1'b1;
    settle(10);
    measure(4, p, h);
    chk("R6 rx bclk follows pin", p, 10);
    measure(5, p, h);
    chk("R6 rx fs follows pin", p, 80);
    hfseen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rx_hf) hfseen++;
    end
    chk("R6 hf held low", hfseen, 0);
    chk("R7 bclk_oe external", int'(rx_bcoe), 0);
    chk("R7 fs_oe external", int'(rx_fsoe), 0);
    chk("R8 hf_oe external", int'(rx_hfoe), 0);
  endtask

  task automatic t_sync();
    int p, h;
    tx_mode = 2'b00; tx_hfd = 5'd0; tx_bd = 5'd1; tx_fl = 6'd3;
    sync_i = 1'b1;
    settle(4);
    measure(4, p, h);
    chk("R9 rx bclk from tx", p, 4);
    measure(5, p, h);
    chk("R9 rx fs from tx", p, 32);
    chk("R9 rx bclk_oe", int'(rx_bcoe), 0);
    chk("R9 rx fs_oe", int'(rx_fsoe), 0);
    sync_i = 1'b0;
    settle(4);
    measure(4, p, h);
    chk("R10 rx own pins", p, 10);
    measure(1, p, h);
    chk("R10 tx unchanged", p, 4);
  endtask

  task automatic t_mode_change();
    int low;
    tx_mode = 2'b10; tx_bcp = 1'b1;
    settle(6);
    chk("R6 tx bclk pin high", int'(tx_bc), 1);
    tx_mode = 2'b00; tx_hfd = 5'd1; tx_bd = 5'd2;
    low = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tx_bc) break;
      low++;
    end
    chk("R11 low samples after switch", low, 2 * 3 + 1);
  endtask

  initial begin : main
    t_reset();
    t_internal();
    t_frame(3, 256);
    t_frame(5, 384);
    t_mixed();
    t_external();
    t_sync();
    t_mode_change();
    finish_run();
  end
endmodule